// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog Reset

This block is the system tick source for a processor subsystem. A 32-bit up-counter advances once for every clock cycle in which the timebase strobe `tickEn` is high. The strobe stands for a fixed 3.6864 MHz reference. Four compare registers each watch the counter. When the counter steps onto a compare value, that channel's sticky status flag is set. The flag stays set until software writes a one to it. Each channel has an interrupt output, which is the registered AND of its status flag and its enable bit.

Software reaches every register through a single-cycle word bus. A write is one cycle with `regWrite` high. A read is combinational on `regAddr`. A periodic tick is kept going by the handler: it clears the status flag and reprograms a compare to a value ahead of the current count. The counter itself can also be rewritten. Once the watchdog is armed, a channel 3 match also produces a one-cycle system reset pulse.

Top module: `os_match_timer`

## Requirements
- R1: The counter adds 1 on each clock edge where `tickEn` is high and no counter write is present. It wraps from 0xFFFFFFFF to 0 and holds its value when `tickEn` is low.
- R2: Compare register n sits at byte offset 4*n (n = 0..3). It can be written and read back in full.
- R3: On a tick edge where the counter's new value equals compare register n, status bit n is set. It stays set through later ticks. The status register is read at offset 0x14, with bit n belonging to channel n and the upper bits reading 0.
- R4: Writing offset 0x14 clears exactly the status bits written as 1 and leaves bits written as 0 alone. If a match and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: The interrupt enable register at offset 0x1C holds bits 3:0, and bit n enables channel n. It reads back what was written.
- R6: `irqOut[n]` equals status bit n AND enable bit n as they stood one clock earlier. It therefore rises one edge after both are 1 and falls one edge after either is cleared.
- R7: Bit 0 of offset 0x18 arms the watchdog and reads back. When armed, a channel 3 match pulses `sysReset` high for exactly one cycle, on the same edge that sets status bit 3. When disarmed, a channel 3 match never raises `sysReset`.
- R8: The counter is written at offset 0x10 and read there. A write wins over a tick in the same cycle. The written value is not compared against the compare registers in that cycle, only from the next tick on.
- R9: Offsets that are not word aligned, or that lie at 0x20 and above, read as 0, and writes to them change nothing.
- R10: After reset, the counter, the compare registers, status, enables and the arm bit are all 0, and `irqOut` and `sysReset` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timebase strobe, one counter step per high cycle |
| regWrite | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 8 | Byte offset of the register accessed |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 4 | Per-channel interrupt, registered status AND enable |
| sysReset | output | 1 | One-cycle system reset pulse from the armed watchdog |

## Verification
The compare logic is tried in four ways. A plain run onto a compare value separates "set on the new count" from "set on the old count". A clear that lands on the same edge as a match exposes the set-over-clear priority. A counter write equal to a compare value, made together with a tick, shows both that the write wins and that the written value is not compared in that cycle. A wrap from 0xFFFFFFFE through zero checks the modulo arithmetic. The watchdog is run over the same channel 3 match twice, once disarmed and once armed, and the high cycles of `sysReset` are counted, which separates a level from a pulse. Interrupt outputs are sampled directly after the enable write and one cycle later, which pins down the register stage.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int MT_CHANNELS = 4;
  localparam int MT_IDX_W    = $clog2(MT_CHANNELS);

  // word indices of the non-compare registers, following the compare block
  localparam int MT_COUNT_WORD  = MT_CHANNELS;
  localparam int MT_STATUS_WORD = MT_CHANNELS + 1;
  localparam int MT_ARM_WORD    = MT_CHANNELS + 2;
  localparam int MT_ENABLE_WORD = MT_CHANNELS + 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MATCH,
    RD_COUNT,
    RD_STATUS,
    RD_ARM,
    RD_ENABLE
  } rdKindT;

  typedef struct packed {
    logic [MT_CHANNELS-1:0] wrMatch;
    logic                   wrCount;
    logic                   wrClear;
    logic                   wrArm;
    logic                   wrEnable;
    rdKindT                 rdKind;
    logic [MT_IDX_W-1:0]    rdIdx;
  } ctrlStrobeT;
endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strobes
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    strobes.rdKind = RD_NONE;
    if (aligned) begin
      if (wordIdx < WORD_W'(MT_CHANNELS)) begin
        strobes.rdKind = RD_MATCH;
        strobes.rdIdx  = wordIdx[MT_IDX_W-1:0];
        for (int n = 0; n < MT_CHANNELS; n++) begin
          strobes.wrMatch[n] = regWrite && (wordIdx == WORD_W'(n));
        end
      end else if (wordIdx == WORD_W'(MT_COUNT_WORD)) begin
        strobes.rdKind  = RD_COUNT;
        strobes.wrCount = regWrite;
      end else if (wordIdx == WORD_W'(MT_STATUS_WORD)) begin
        strobes.rdKind  = RD_STATUS;
        strobes.wrClear = regWrite;
      end else if (wordIdx == WORD_W'(MT_ARM_WORD)) begin
        strobes.rdKind = RD_ARM;
        strobes.wrArm  = regWrite;
      end else if (wordIdx == WORD_W'(MT_ENABLE_WORD)) begin
        strobes.rdKind   = RD_ENABLE;
        strobes.wrEnable = regWrite;
      end
    end
  end
endmodule

// File: rtl/mt_datapath.sv
module mt_datapath
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic [CNT_W-1:0]       regWdata,
  input  ctrlStrobeT             strobes,
  output logic [CNT_W-1:0]       regRdata,
  output logic [MT_CHANNELS-1:0] irqOut,
  output logic                   sysReset,
  output logic [CNT_W-1:0]       countVal,
  output logic [MT_CHANNELS-1:0] statusVec,
  output logic [MT_CHANNELS-1:0] enableVec,
  output logic                   armBit
);
  localparam int WDOG_CH = MT_CHANNELS - 1;

  logic [CNT_W-1:0]       matchReg [MT_CHANNELS];
  logic [CNT_W-1:0]       countNext;
  logic [MT_CHANNELS-1:0] matchHit;
  logic [MT_CHANNELS-1:0] clearMask;
  logic                   stepping;

  assign countNext = countVal + CNT_W'(1);
  assign stepping  = tickEn && !strobes.wrCount;
  assign clearMask = strobes.wrClear ? regWdata[MT_CHANNELS-1:0] : '0;

  for (genvar ch = 0; ch < MT_CHANNELS; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchReg[ch] <= '0;
      end else if (strobes.wrMatch[ch]) begin
        matchReg[ch] <= regWdata;
      end
    end
    assign matchHit[ch] = stepping && (countNext == matchReg[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobes.wrCount) begin
      countVal <= regWdata;
    end else if (tickEn) begin
      countVal <= countNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusVec <= '0;
      enableVec <= '0;
      armBit    <= 1'b0;
      irqOut    <= '0;
      sysReset  <= 1'b0;
    end else begin
      statusVec <= (statusVec & ~clearMask) | matchHit;
      if (strobes.wrEnable) enableVec <= regWdata[MT_CHANNELS-1:0];
      if (strobes.wrArm)    armBit    <= regWdata[0];
      irqOut   <= statusVec & enableVec;
      sysReset <= armBit && matchHit[WDOG_CH];
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (strobes.rdKind)
      RD_MATCH:  regRdata = matchReg[strobes.rdIdx];
      RD_COUNT:  regRdata = countVal;
      RD_STATUS: regRdata = CNT_W'(statusVec);
      RD_ARM:    regRdata = CNT_W'(armBit);
      RD_ENABLE: regRdata = CNT_W'(enableVec);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic                   regWrite,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [CNT_W-1:0]       regWdata,
  output logic [CNT_W-1:0]       regRdata,
  output logic [MT_CHANNELS-1:0] irqOut,
  output logic                   sysReset
);
  ctrlStrobeT             strobes;
  logic [CNT_W-1:0]       countVal;
  logic [MT_CHANNELS-1:0] statusVec;
  logic [MT_CHANNELS-1:0] enableVec;
  logic                   armBit;

  mt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobes  (strobes)
  );

  mt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .regWdata  (regWdata),
    .strobes   (strobes),
    .regRdata  (regRdata),
    .irqOut    (irqOut),
    .sysReset  (sysReset),
    .countVal  (countVal),
    .statusVec (statusVec),
    .enableVec (enableVec),
    .armBit    (armBit)
  );
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   tickEn,
  input logic                   regWrite,
  input logic [ADDR_W-1:0]      regAddr,
  input logic [CNT_W-1:0]       regWdata,
  input logic [MT_CHANNELS-1:0] irqOut,
  input logic                   sysReset,
  input logic [CNT_W-1:0]       countVal,
  input logic [MT_CHANNELS-1:0] statusVec,
  input logic [MT_CHANNELS-1:0] enableVec,
  input logic                   armBit
);
  localparam logic [ADDR_W-1:0] COUNT_OFF  = ADDR_W'(MT_COUNT_WORD * 4);
  localparam logic [ADDR_W-1:0] STATUS_OFF = ADDR_W'(MT_STATUS_WORD * 4);

  logic cntWr;
  logic stsWr;
  assign cntWr = regWrite && (regAddr == COUNT_OFF);
  assign stsWr = regWrite && (regAddr == STATUS_OFF);

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWr) |=> $stable(countVal)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cntWr) |=> (countVal == $past(countVal) + CNT_W'(1))); // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stsWr |=> ((statusVec & $past(statusVec)) == $past(statusVec))); // R3
  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(statusVec & enableVec))); // R6
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> !sysReset); // R7
  AST_RESET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> $past(armBit)); // R7
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (countVal == $past(regWdata))); // R8
endmodule

bind os_match_timer mt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/os_match_timer_test.sv
`timescale 1ns/1ps
module os_match_timer_test;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  irqOut;
  logic        sysReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  os_match_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqOut(irqOut), .sysReset(sysReset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int a = 0; a < 32; a += 4) begin
      busRead(8'(a), d);
      check("R10 reset register value", d, 32'h0);
    end
    check("R10 reset irqOut", 32'(irqOut), 32'h0);
    check("R10 reset sysReset", 32'(sysReset), 32'h0);
  endtask

  task automatic testCompareRegs();
    logic [31:0] d;
    for (int n = 0; n < 4; n++) busWrite(8'(n * 4), 32'hA000_0000 + 32'(n));
    for (int n = 0; n < 4; n++) begin
      busRead(8'(n * 4), d);
      check("R2 compare readback", d, 32'hA000_0000 + 32'(n));
    end
    busWrite(8'h02, 32'h1234_5678);
    busWrite(8'h24, 32'h1234_5678);
    busRead(8'h02, d);
    check("R9 unaligned read zero", d, 32'h0);
    busRead(8'h24, d);
    check("R9 high offset read zero", d, 32'h0);
    busRead(8'h00, d);
    check("R9 ignored write left compare 0", d, 32'hA000_0000);
  endtask

  task automatic testCounter();
    logic [31:0] d;
    busWrite(8'h10, 32'd100);
    busRead(8'h10, d);
    check("R8 counter write readback", d, 32'd100);
    ticks(5);
    busRead(8'h10, d);
    check("R1 counter after 5 ticks", d, 32'd105);
    repeat (3) @(negedge clk);
    busRead(8'h10, d);
    check("R1 counter holds without tick", d, 32'd105);
    busWrite(8'h10, 32'hFFFF_FFFE);
    ticks(2);
    busRead(8'h10, d);
    check("R1 counter wraps to zero", d, 32'h0);
  endtask

  task automatic testMatch();
    logic [31:0] d;
    busWrite(8'h10, 32'd0);
    busWrite(8'h04, 32'd3);
    ticks(2);
    busRead(8'h14, d);
    check("R3 no status before match", d, 32'h0);
    ticks(1);
    busRead(8'h14, d);
    check("R3 status set on match", d, 32'h2);
    ticks(2);
    busRead(8'h14, d);
    check("R3 status sticky", d, 32'h2);
    busWrite(8'h14, 32'h1);
    busRead(8'h14, d);
    check("R4 zero bits leave status", d, 32'h2);
    busWrite(8'h14, 32'h2);
    busRead(8'h14, d);
    check("R4 one bit clears status", d, 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    busWrite(8'h10, 32'd10);
    busWrite(8'h08, 32'd11);
    ticks(1);
    busRead(8'h14, d);
    check("R3 channel 2 set", d, 32'h4);
    busWrite(8'h10, 32'd10);
    @(negedge clk);
    tickEn = 1'b1; regWrite = 1'b1; regAddr = 8'h14; regWdata = 32'h4;
    @(negedge clk);
    tickEn = 1'b0; regWrite = 1'b0;
    busRead(8'h14, d);
    check("R4 set wins over clear", d, 32'h4);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    check("R6 irq low while disabled", 32'(irqOut), 32'h0);
    busWrite(8'h1C, 32'hF);
    busRead(8'h1C, d);
    check("R5 enable readback", d, 32'hF);
    check("R6 irq not yet after enable", 32'(irqOut), 32'h0);
    @(negedge clk);
    check("R6 irq one cycle after enable", 32'(irqOut), 32'h4);
    busWrite(8'h1C, 32'h0);
    @(negedge clk);
    check("R5 disable drops irq", 32'(irqOut), 32'h0);
    busWrite(8'h14, 32'hF);
  endtask

  task automatic testCountPriority();
    logic [31:0] d;
    busWrite(8'h00, 32'd50);
    busWrite(8'h10, 32'd20);
    @(negedge clk);
    tickEn = 1'b1; regWrite = 1'b1; regAddr = 8'h10; regWdata = 32'd50;
    @(negedge clk);
    tickEn = 1'b0; regWrite = 1'b0;
    busRead(8'h10, d);
    check("R8 write beats tick", d, 32'd50);
    busRead(8'h14, d);
    check("R8 written value not compared", d, 32'h0);
    ticks(1);
    busRead(8'h10, d);
    check("R8 counting resumes", d, 32'd51);
  endtask

  task automatic testWatchdog();
    logic [31:0] d;
    int highs;
    busWrite(8'h0C, 32'd200);
    busWrite(8'h10, 32'd198);
    highs = 0;
    @(negedge clk);
    tickEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sysReset) highs++;
    end
    tickEn = 1'b0;
    check("R7 disarmed no reset", 32'(highs), 32'd0);
    busRead(8'h14, d);
    check("R3 channel 3 status set", d, 32'h8);
    busWrite(8'h14, 32'hF);
    busWrite(8'h18, 32'h1);
    busRead(8'h18, d);
    check("R7 arm readback", d, 32'h1);
    busWrite(8'h10, 32'd198);
    highs = 0;
    @(negedge clk);
    tickEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sysReset) highs++;
      if (i == 1) check("R7 reset on match edge", 32'(sysReset), 32'h1);
    end
    tickEn = 1'b0;
    check("R7 single-cycle pulse", 32'(highs), 32'd1);
    busWrite(8'h18, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCompareRegs();
    testCounter();
    testMatch();
    testSetWins();
    testIrq();
    testCountPriority();
    testWatchdog();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule